// File: doc/BRIEF.md
# Multithreaded Windowed Register File

This block holds the integer registers of many hardware threads in one shared storage array. Each thread owns a private 64-word slice, and the physical word address is the thread number concatenated with a 6-bit slot. The slot comes from the architectural register number r0..r31 and the thread's current window pointer. Globals, the trap base register, a set of scratch words for microcode and three overlapping register windows all live in that slice. The window pointer is supplied by the pipeline on every access. This block does not update the pointer and does not check for window overflow.

Two read ports and one write port work in parallel. Reads are registered and return data one cycle after the address is presented. Each stored word carries an even-parity bit, and every read reports whether the word it returned still matches that bit.

The pipeline uses it like a normal register file: it presents thread, window pointer and register number each cycle. A microcode-mode flag redirects an access to the trap base register or the scratch words through a 3-bit index.

Top module: `multithread_wrf`

## Requirements
- R1: The physical address is {thread, slot}, so a write by one thread never changes the same register of another thread. The highest thread number is fully usable.
- R2: Registers r1..r7 map to slots 1..7 and are shared by all windows: the value read does not depend on the window pointer.
- R3: Register r0 always reads as zero with the parity error flag low, and a write to r0 changes no stored word.
- R4: For r8..r31 with window pointer w, the slot is 16 + ((16*w + r - 8) mod 48). The locals r16..r23 are distinct in each of the three windows.
- R5: The ins r24..r31 of window w are the same words as the outs r8..r15 of window (w+1) mod 3, and window 2 wraps onto window 0.
- R6: A window pointer value of 3 selects the same words as value 0.
- R7: With microcode mode set, scratch index i (0..7) selects slot 8+i, and index 0 is the trap base register. The register number is ignored in this mode.
- R8: Each read port returns the word addressed in cycle N after the clock edge that ends cycle N. Until that edge it keeps its previous value. The two ports are independent.
- R9: A read and a write to the same address in the same cycle return the old contents. The new value is visible from the next cycle on.
- R10: Every written word is stored with an even-parity bit (XOR of the data). A read of a correctly stored word reports parity error low, and the flag rises only when the stored bit disagrees with the data.
- R11: While the synchronous active-low reset is low, both read outputs and both error flags are zero, and writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ra_tid | input | TID_W (3) | Read port A thread number |
| ra_cwp | input | 2 | Read port A window pointer |
| ra_ucode | input | 1 | Read port A microcode mode |
| ra_reg | input | 5 | Read port A register number |
| ra_scr | input | 3 | Read port A scratch index |
| ra_data | output | XLEN (32) | Read port A data |
| ra_perr | output | 1 | Read port A parity error |
| rb_tid | input | TID_W (3) | Read port B thread number |
| rb_cwp | input | 2 | Read port B window pointer |
| rb_ucode | input | 1 | Read port B microcode mode |
| rb_reg | input | 5 | Read port B register number |
| rb_scr | input | 3 | Read port B scratch index |
| rb_data | output | XLEN (32) | Read port B data |
| rb_perr | output | 1 | Read port B parity error |
| w_en | input | 1 | Write enable |
| w_tid | input | TID_W (3) | Write thread number |
| w_cwp | input | 2 | Write window pointer |
| w_ucode | input | 1 | Write microcode mode |
| w_reg | input | 5 | Write register number |
| w_scr | input | 3 | Write scratch index |
| w_data | input | XLEN (32) | Write data |

## Verification
The stimulus table writes globals, locals, ins, microcode words and r0 through different window pointers and threads. It then reads them back through other names.

- Reading a global under another window pointer separates shared globals from windowed registers.
- Reading locals under each pointer shows that the three windows are distinct.
- Reading an in through the outs of the next window, including the wrap from window 2 to window 0, confirms the modulo-48 aliasing.
- Pointer value 3, scratch index 0 against 7, and the same register in two threads probe the remaining address bits.

Directed tests then cover:
- read-before-write on a same-cycle collision;
- the one-cycle read latency on both ports at once;
- the top thread number;
- writes attempted during reset.

// File: rtl/mtwrf_pkg.sv
// Package: shared constants and the window-slot function of the
// multithreaded windowed register file. Assumes three windows of 16 slots
// placed after a 16-slot block of globals, trap base and scratch words.
package mtwrf_pkg;

    localparam int SLOT_W        = 6;   // slot bits inside one thread slice
    localparam int REG_W         = 5;   // architectural register number bits
    localparam int SCR_W         = 3;   // microcode scratch index bits
    localparam int CWP_W         = 2;   // window pointer bits
    localparam int NUM_WIN       = 3;   // windows per thread
    localparam int WIN_STRIDE    = 16;  // slots a window advances by
    localparam int TBR_SLOT      = 8;   // trap base register slot
    localparam int WIN_BASE      = 16;  // first windowed slot
    localparam int WIN_SPAN      = NUM_WIN * WIN_STRIDE;
    localparam int WIN_FIRST_REG = 8;   // first windowed architectural reg
    localparam int LIN_W         = 7;   // width holding 16*3 + 23

    // Map a windowed register (r8..r31) under a window pointer onto its slot.
    function automatic logic [SLOT_W-1:0] win_slot(
        input logic [CWP_W-1:0] cwp,
        input logic [REG_W-1:0] arch
    );
        logic [LIN_W-1:0] lin;
        lin = LIN_W'(cwp) * LIN_W'(WIN_STRIDE) + LIN_W'(arch) - LIN_W'(WIN_FIRST_REG);
        if (lin >= LIN_W'(WIN_SPAN)) begin
            lin = lin - LIN_W'(WIN_SPAN);
        end
        return SLOT_W'(WIN_BASE) + SLOT_W'(lin);
    endfunction

endpackage

// File: rtl/mtwrf_slot_map.sv
// Module: mtwrf_slot_map
// Turns an access request (microcode flag, register number, scratch index,
// window pointer) into a 6-bit slot of the thread slice. It flags accesses
// to r0 so that the caller can force zero on reads and drop writes.
// Purely combinational. It assumes the caller prepends the thread number.
module mtwrf_slot_map
    import mtwrf_pkg::*;
(
    input  logic              ucode,
    input  logic [REG_W-1:0]  arch_reg,
    input  logic [SCR_W-1:0]  scr_idx,
    input  logic [CWP_W-1:0]  cwp,
    output logic [SLOT_W-1:0] slot,
    output logic              is_zero
);

    // Select the slot by access class: microcode, global or windowed.
    always_comb begin
        slot    = '0;
        is_zero = 1'b0;
        if (ucode) begin
            slot = SLOT_W'(TBR_SLOT) + SLOT_W'(scr_idx);
        end else if (arch_reg < REG_W'(WIN_FIRST_REG)) begin
            slot    = SLOT_W'(arch_reg);
            is_zero = (arch_reg == '0);
        end else begin
            slot = win_slot(cwp, arch_reg);
        end
    end

endmodule

// File: rtl/mtwrf_parity_array.sv
// Module: mtwrf_parity_array
// Word storage with one write port and NRD registered read ports. Each word
// is stored with an even-parity bit. Every read reports a mismatch between
// the data and that bit. A read and a write to one address in the same
// cycle return the old word. The array is not reset. Only the read
// registers clear on reset.
module mtwrf_parity_array #(
    parameter int AW  = 9,
    parameter int DW  = 32,
    parameter int NRD = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [DW-1:0]           wdata,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0][DW-1:0]  rdata,
    output logic [NRD-1:0]          rerr
);

    localparam int DEPTH = 1 << AW;

    logic [DW:0] mem [DEPTH];

    // Store the data word together with its parity bit.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= {^wdata, wdata};
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        logic [DW:0] word_q;

        // Register the addressed word; the old content wins on collision.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else begin
                word_q <= mem[raddr[p]];
            end
        end

        assign rdata[p] = word_q[DW-1:0];
        assign rerr[p]  = (^word_q[DW-1:0]) != word_q[DW];

        AST_WRITE_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(we) && raddr[p] == $past(waddr)) |=> (rdata[p] == $past(wdata, 2) && !rerr[p])); // R10
    end

endmodule

// File: rtl/multithread_wrf.sv
// Module: multithread_wrf (top)
// Integer register file shared by THREADS hardware threads. Each thread owns
// a 64-word slice: globals, trap base, microcode scratch words and three
// overlapping windows. It has two read ports with one-cycle latency and
// one write port. r0 reads as zero and is not writable. A parity error flag
// comes with each read. The window pointer is taken as given, and the
// caller is assumed to handle window overflow checks.
module multithread_wrf
    import mtwrf_pkg::*;
#(
    parameter int THREADS = 8,
    parameter int XLEN    = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(THREADS)-1:0] ra_tid,
    input  logic [1:0]                 ra_cwp,
    input  logic                       ra_ucode,
    input  logic [4:0]                 ra_reg,
    input  logic [2:0]                 ra_scr,
    output logic [XLEN-1:0]            ra_data,
    output logic                       ra_perr,
    input  logic [$clog2(THREADS)-1:0] rb_tid,
    input  logic [1:0]                 rb_cwp,
    input  logic                       rb_ucode,
    input  logic [4:0]                 rb_reg,
    input  logic [2:0]                 rb_scr,
    output logic [XLEN-1:0]            rb_data,
    output logic                       rb_perr,
    input  logic                       w_en,
    input  logic [$clog2(THREADS)-1:0] w_tid,
    input  logic [1:0]                 w_cwp,
    input  logic                       w_ucode,
    input  logic [4:0]                 w_reg,
    input  logic [2:0]                 w_scr,
    input  logic [XLEN-1:0]            w_data
);

    localparam int TID_W = $clog2(THREADS);
    localparam int AW    = TID_W + SLOT_W;
    localparam int NRD   = 2;

    logic [NRD-1:0][TID_W-1:0]  rd_tid;
    logic [NRD-1:0][CWP_W-1:0]  rd_cwp;
    logic [NRD-1:0]             rd_ucode;
    logic [NRD-1:0][REG_W-1:0]  rd_reg;
    logic [NRD-1:0][SCR_W-1:0]  rd_scr;
    logic [NRD-1:0][SLOT_W-1:0] rd_slot;
    logic [NRD-1:0]             rd_zero;
    logic [NRD-1:0][AW-1:0]     rd_addr;
    logic [NRD-1:0][XLEN-1:0]   arr_rdata;
    logic [NRD-1:0]             arr_rerr;
    logic [NRD-1:0][XLEN-1:0]   rd_out;
    logic [NRD-1:0]             rd_perr;

    logic [SLOT_W-1:0]          wr_slot;
    logic                       wr_zero;
    logic                       arr_we;

    assign rd_tid   = {rb_tid,   ra_tid};
    assign rd_cwp   = {rb_cwp,   ra_cwp};
    assign rd_ucode = {rb_ucode, ra_ucode};
    assign rd_reg   = {rb_reg,   ra_reg};
    assign rd_scr   = {rb_scr,   ra_scr};

    assign ra_data = rd_out[0];
    assign rb_data = rd_out[1];
    assign ra_perr = rd_perr[0];
    assign rb_perr = rd_perr[1];

    for (genvar p = 0; p < NRD; p++) begin : g_port
        logic zero_q;

        mtwrf_slot_map u_map (
            .ucode    (rd_ucode[p]),
            .arch_reg (rd_reg[p]),
            .scr_idx  (rd_scr[p]),
            .cwp      (rd_cwp[p]),
            .slot     (rd_slot[p]),
            .is_zero  (rd_zero[p])
        );

        assign rd_addr[p] = {rd_tid[p], rd_slot[p]};

        // Remember that the read in flight targets r0.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                zero_q <= 1'b0;
            end else begin
                zero_q <= rd_zero[p];
            end
        end

        assign rd_out[p]  = zero_q ? '0 : arr_rdata[p];
        assign rd_perr[p] = zero_q ? 1'b0 : arr_rerr[p];

        AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (!rd_ucode[p] && rd_reg[p] == '0) |=> (rd_out[p] == '0 && !rd_perr[p])); // R3
        AST_GLOBAL_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
            (!rd_ucode[p] && rd_reg[p] < REG_W'(WIN_FIRST_REG)) |-> (rd_slot[p] == SLOT_W'(rd_reg[p]))); // R2
        AST_WIN_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            (!rd_ucode[p] && rd_reg[p] >= REG_W'(WIN_FIRST_REG)) |-> (rd_slot[p] >= SLOT_W'(WIN_BASE))); // R4
        AST_UCODE_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            rd_ucode[p] |-> (rd_slot[p] >= SLOT_W'(TBR_SLOT) && rd_slot[p] < SLOT_W'(WIN_BASE))); // R7
        AST_RESET_QUIET: assert property (@(posedge clk)
            !rst_n |=> (rd_out[p] == '0 && !rd_perr[p])); // R11
    end

    mtwrf_slot_map u_wmap (
        .ucode    (w_ucode),
        .arch_reg (w_reg),
        .scr_idx  (w_scr),
        .cwp      (w_cwp),
        .slot     (wr_slot),
        .is_zero  (wr_zero)
    );

    assign arr_we = w_en && rst_n && !wr_zero;

    AST_R0_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (w_en && !w_ucode && w_reg == '0) |-> !arr_we); // R3

    mtwrf_parity_array #(
        .AW  (AW),
        .DW  (XLEN),
        .NRD (NRD)
    ) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (arr_we),
        .waddr ({w_tid, wr_slot}),
        .wdata (w_data),
        .raddr (rd_addr),
        .rdata (arr_rdata),
        .rerr  (arr_rerr)
    );

endmodule

// File: tb/multithread_wrf_tb_top.sv
// Bench: table-driven writes and reads, then directed reset/corner tests.
module multithread_wrf_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 23;

    typedef struct packed {
        logic        wr;
        logic [2:0]  tid;
        logic [1:0]  cwp;
        logic        uc;
        logic [4:0]  rg;
        logic [2:0]  scr;
        logic [31:0] dat;
        logic [7:0]  req;
    } vec_t;

    // Rows: wr, tid, cwp, ucode, reg, scr, data (write value or expected read), req
    localparam vec_t TBL [NVEC] = '{
        '{1'b1, 3'd1, 2'd0, 1'b0, 5'd1,  3'd0, 32'h1111_1111, 8'd2},  // R2 global g1 thread 1
        '{1'b1, 3'd2, 2'd0, 1'b0, 5'd1,  3'd0, 32'h2222_2222, 8'd1},  // R1 same reg thread 2
        '{1'b1, 3'd1, 2'd0, 1'b0, 5'd16, 3'd0, 32'hA000_0016, 8'd4},  // R4 local w0
        '{1'b1, 3'd1, 2'd1, 1'b0, 5'd16, 3'd0, 32'hA100_0016, 8'd4},  // R4 local w1
        '{1'b1, 3'd1, 2'd2, 1'b0, 5'd16, 3'd0, 32'hA200_0016, 8'd4},  // R4 local w2
        '{1'b1, 3'd1, 2'd0, 1'b0, 5'd24, 3'd0, 32'hB000_0024, 8'd5},  // R5 in of w0
        '{1'b1, 3'd1, 2'd2, 1'b0, 5'd25, 3'd0, 32'hB200_0025, 8'd5},  // R5 in of w2 (wraps)
        '{1'b1, 3'd1, 2'd1, 1'b0, 5'd31, 3'd0, 32'hE100_0031, 8'd5},  // R5 in of w1
        '{1'b1, 3'd1, 2'd0, 1'b1, 5'd0,  3'd0, 32'hC000_0000, 8'd7},  // R7 trap base
        '{1'b1, 3'd1, 2'd0, 1'b1, 5'd9,  3'd7, 32'hC700_0007, 8'd7},  // R7 scratch 7
        '{1'b1, 3'd1, 2'd0, 1'b0, 5'd0,  3'd0, 32'hDEAD_BEEF, 8'd3},  // R3 write r0
        '{1'b0, 3'd1, 2'd2, 1'b0, 5'd1,  3'd0, 32'h1111_1111, 8'd2},  // R2 g1 via w2
        '{1'b0, 3'd2, 2'd1, 1'b0, 5'd1,  3'd0, 32'h2222_2222, 8'd1},  // R1 thread 2 kept
        '{1'b0, 3'd1, 2'd0, 1'b0, 5'd16, 3'd0, 32'hA000_0016, 8'd4},  // R4
        '{1'b0, 3'd1, 2'd1, 1'b0, 5'd16, 3'd0, 32'hA100_0016, 8'd4},  // R4
        '{1'b0, 3'd1, 2'd2, 1'b0, 5'd16, 3'd0, 32'hA200_0016, 8'd4},  // R4
        '{1'b0, 3'd1, 2'd1, 1'b0, 5'd8,  3'd0, 32'hB000_0024, 8'd5},  // R5 w0 r24 = w1 r8
        '{1'b0, 3'd1, 2'd0, 1'b0, 5'd9,  3'd0, 32'hB200_0025, 8'd5},  // R5 w2 r25 = w0 r9
        '{1'b0, 3'd1, 2'd2, 1'b0, 5'd15, 3'd0, 32'hE100_0031, 8'd5},  // R5 w1 r31 = w2 r15
        '{1'b0, 3'd1, 2'd3, 1'b0, 5'd16, 3'd0, 32'hA000_0016, 8'd6},  // R6 pointer 3 = 0
        '{1'b0, 3'd1, 2'd2, 1'b1, 5'd20, 3'd0, 32'hC000_0000, 8'd7},  // R7 reg ignored
        '{1'b0, 3'd1, 2'd0, 1'b1, 5'd0,  3'd7, 32'hC700_0007, 8'd7},  // R7
        '{1'b0, 3'd1, 2'd1, 1'b0, 5'd0,  3'd0, 32'h0000_0000, 8'd3}   // R3 r0 reads zero
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  ra_tid, rb_tid, w_tid;
    logic [1:0]  ra_cwp, rb_cwp, w_cwp;
    logic        ra_ucode, rb_ucode, w_ucode;
    logic [4:0]  ra_reg, rb_reg, w_reg;
    logic [2:0]  ra_scr, rb_scr, w_scr;
    logic [31:0] ra_data, rb_data, w_data;
    logic        ra_perr, rb_perr, w_en;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    multithread_wrf #(.THREADS(8), .XLEN(32)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .ra_tid(ra_tid), .ra_cwp(ra_cwp), .ra_ucode(ra_ucode), .ra_reg(ra_reg),
        .ra_scr(ra_scr), .ra_data(ra_data), .ra_perr(ra_perr),
        .rb_tid(rb_tid), .rb_cwp(rb_cwp), .rb_ucode(rb_ucode), .rb_reg(rb_reg),
        .rb_scr(rb_scr), .rb_data(rb_data), .rb_perr(rb_perr),
        .w_en(w_en), .w_tid(w_tid), .w_cwp(w_cwp), .w_ucode(w_ucode),
        .w_reg(w_reg), .w_scr(w_scr), .w_data(w_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic set_a(input logic [2:0] t, input logic [1:0] c, input logic u,
                         input logic [4:0] r, input logic [2:0] s);
        ra_tid = t; ra_cwp = c; ra_ucode = u; ra_reg = r; ra_scr = s;
    endtask

    task automatic set_b(input logic [2:0] t, input logic [1:0] c, input logic u,
                         input logic [4:0] r, input logic [2:0] s);
        rb_tid = t; rb_cwp = c; rb_ucode = u; rb_reg = r; rb_scr = s;
    endtask

    task automatic set_w(input logic e, input logic [2:0] t, input logic [1:0] c,
                         input logic u, input logic [4:0] r, input logic [2:0] s,
                         input logic [31:0] d);
        w_en = e; w_tid = t; w_cwp = c; w_ucode = u; w_reg = r; w_scr = s; w_data = d;
    endtask

    // Single write, called and returning at a falling edge.
    task automatic wr(input logic [2:0] t, input logic [1:0] c, input logic u,
                      input logic [4:0] r, input logic [2:0] s, input logic [31:0] d);
        set_w(1'b1, t, c, u, r, s, d);
        @(negedge clk);
        w_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin : main
        rst_n = 1'b0;
        set_a(3'd0, 2'd0, 1'b0, 5'd0, 3'd0);
        set_b(3'd0, 2'd0, 1'b0, 5'd0, 3'd0);
        set_w(1'b0, 3'd0, 2'd0, 1'b0, 5'd0, 3'd0, 32'h0);
        repeat (3) @(negedge clk);
        chk("R11 reset data A", ra_data, 32'h0);
        chk("R11 reset data B", rb_data, 32'h0);
        chk("R11 reset perr", {30'h0, rb_perr, ra_perr}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: writes, then reads alternating between ports.
        for (int i = 0; i < NVEC; i++) begin
            if (TBL[i].wr) begin
                wr(TBL[i].tid, TBL[i].cwp, TBL[i].uc, TBL[i].rg, TBL[i].scr, TBL[i].dat);
            end else if (i % 2 == 0) begin
                set_a(TBL[i].tid, TBL[i].cwp, TBL[i].uc, TBL[i].rg, TBL[i].scr);
                @(negedge clk);
                chk($sformatf("R%0d row %0d port A", TBL[i].req, i), ra_data, TBL[i].dat);
                chk($sformatf("R10 row %0d port A perr", i), {31'h0, ra_perr}, 32'h0);
            end else begin
                set_b(TBL[i].tid, TBL[i].cwp, TBL[i].uc, TBL[i].rg, TBL[i].scr);
                @(negedge clk);
                chk($sformatf("R%0d row %0d port B", TBL[i].req, i), rb_data, TBL[i].dat);
                chk($sformatf("R10 row %0d port B perr", i), {31'h0, rb_perr}, 32'h0);
            end
        end

        // R1: highest thread number, isolated from thread 1.
        wr(3'd7, 2'd2, 1'b0, 5'd31, 3'd0, 32'h7777_0031);
        set_a(3'd7, 2'd2, 1'b0, 5'd31, 3'd0);
        set_b(3'd1, 2'd1, 1'b0, 5'd31, 3'd0);
        @(negedge clk);
        chk("R1 top thread", ra_data, 32'h7777_0031);
        chk("R1 thread 1 untouched", rb_data, 32'hE100_0031);

        // R8: latency on both ports at once; outputs hold until the edge.
        set_a(3'd1, 2'd0, 1'b0, 5'd16, 3'd0);
        set_b(3'd1, 2'd0, 1'b1, 5'd0, 3'd0);
        #1;
        chk("R8 A holds before edge", ra_data, 32'h7777_0031);
        chk("R8 B holds before edge", rb_data, 32'hE100_0031);
        @(negedge clk);
        chk("R8 A after edge", ra_data, 32'hA000_0016);
        chk("R8 B after edge", rb_data, 32'hC000_0000);

        // R9: same-cycle read and write to one address.
        wr(3'd3, 2'd0, 1'b0, 5'd3, 3'd0, 32'h0000_0001);
        set_a(3'd3, 2'd1, 1'b0, 5'd3, 3'd0);
        set_w(1'b1, 3'd3, 2'd0, 1'b0, 5'd3, 3'd0, 32'h0000_0002);
        @(negedge clk);
        w_en = 1'b0;
        chk("R9 old value on collision", ra_data, 32'h0000_0001);
        @(negedge clk);
        chk("R9 new value next cycle", ra_data, 32'h0000_0002);
        chk("R10 odd-weight word no perr", {31'h0, ra_perr}, 32'h0);

        // R3: the r0 write earlier left slot 0 unused; r0 still reads zero.
        set_b(3'd1, 2'd2, 1'b0, 5'd0, 3'd0);
        @(negedge clk);
        chk("R3 r0 after write", rb_data, 32'h0);

        // R11: writes during reset are dropped; outputs are zero in reset.
        wr(3'd0, 2'd0, 1'b0, 5'd2, 3'd0, 32'h1234_5678);
        set_a(3'd0, 2'd0, 1'b0, 5'd2, 3'd0);
        rst_n = 1'b0;
        set_w(1'b1, 3'd0, 2'd0, 1'b0, 5'd2, 3'd0, 32'h0BAD_BAD0);
        @(negedge clk);
        @(negedge clk);
        w_en = 1'b0;
        chk("R11 data zero in reset", ra_data, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 write in reset ignored", ra_data, 32'h1234_5678);

        summary();
    end

endmodule